// File: doc/BRIEF.md
# Accumulator Processor with Step Sequencer

This block is a small 8-bit processor built around a single accumulator and a 16-byte internal memory that holds both the program and its data. A control sequencer walks each instruction through a fixed chain of register transfers. The program counter goes to the address register and memory is read into the data register. The byte is latched as the instruction. Its address field then goes back to the address register, and the operand is read and applied to the accumulator or written back to memory.

A test harness fills the memory through a preload port while the core is held in reset. After reset is released the core runs from address 0 until it meets a halt instruction. The program counter, accumulator and a halted indicator are brought out so that progress can be observed from outside.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high the program counter reads 0, the accumulator reads 0 and the halted output is low, including after a previous run that ended halted.
- R2: The preload port (write enable, 4-bit address, 8-bit data) writes memory only while reset is high; a preload write attempted while the core runs leaves memory unchanged.
- R3: An instruction byte carries the opcode in bits 7:4 and the operand address in bits 3:0; opcode 0x1 is load, 0x2 is add, 0x3 is store and 0xF is halt.
- R4: A load copies the byte at the operand address into the accumulator.
- R5: An add replaces the accumulator with the accumulator plus the byte at the operand address, modulo 256, with no carry kept.
- R6: A store writes the accumulator to the operand address and leaves the accumulator unchanged; a later load of that address returns the stored value.
- R7: Each non-halt instruction takes exactly six clock cycles, and the program counter advances by one on the last of them.
- R8: Any opcode other than 0x1, 0x2, 0x3 and 0xF changes nothing except advancing the program counter.
- R9: The program counter wraps from 15 to 0.
- R10: A halt instruction raises the halted output four cycles after its fetch begins and then holds the program counter and accumulator frozen until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables the preload port |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | 4 | Preload memory address |
| ld_data | input | 8 | Preload data byte |
| pc_o | output | 4 | Current program counter |
| acc_o | output | 8 | Current accumulator value |
| halted_o | output | 1 | High once a halt instruction has been decoded |

## Verification
A corrupted sequencer step or misrouted transfer shows up at the ports within one instruction, six cycles at most. The program counter moves too early or too late, or the accumulator takes a wrong value at the moment the counter advances. A wrong memory write stays hidden until a later load of the same address brings it into the accumulator, so every program stores and then reloads a location. An opcode decoded wrongly either changes the accumulator where it must not or raises the halted output off its fourth-cycle slot.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam int OP_W   = DATA_W - ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [OP_W-1:0]   opcode_t;

    localparam opcode_t OPC_LOAD  = OP_W'(4'h1);
    localparam opcode_t OPC_ADD   = OP_W'(4'h2);
    localparam opcode_t OPC_STORE = OP_W'(4'h3);
    localparam opcode_t OPC_HALT  = OP_W'(4'hF);

    typedef struct packed {
        opcode_t op;
        addr_t   addr;
    } instr_t;

    typedef enum logic [2:0] {
        ST_FETCH_MAR = 3'd0,
        ST_FETCH_MDR = 3'd1,
        ST_FETCH_IR  = 3'd2,
        ST_OPND_MAR  = 3'd3,
        ST_OPND_MDR  = 3'd4,
        ST_EXEC      = 3'd5,
        ST_HALT      = 3'd6
    } step_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic mdr_load;
        logic ir_load;
        logic acc_load;
        logic acc_add;
        logic mem_we;
        logic pc_inc;
    } ctrl_t;

    function automatic word_t alu_sum(input word_t a, input word_t b);
        return a + b;
    endfunction

    function automatic addr_t addr_next(input addr_t a);
        return a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_we,
    input  addr_t ld_addr,
    input  word_t ld_data,
    input  addr_t core_addr,
    input  logic  core_we,
    input  word_t core_wdata,
    output word_t core_rdata
);

    word_t cells [DEPTH];

    logic  wr_en;
    addr_t wr_addr;
    word_t wr_data;

    always_comb begin
        wr_en   = 1'b0;
        wr_addr = core_addr;
        wr_data = core_wdata;
        if (rst) begin
            wr_en   = ld_we;
            wr_addr = ld_addr;
            wr_data = ld_data;
        end else if (core_we) begin
            wr_en = 1'b1;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == addr_t'(i))) begin
                cells[i] <= wr_data;
            end
        end
    end

    assign core_rdata = cells[core_addr];

    // R2
    core_write_in_run_chk: assert property (@(posedge clk) core_we |-> !rst)
        else $error("core write while in reset");

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_t opcode,
    output ctrl_t   ctl,
    output logic    exec_o,
    output logic    halted_o
);

    step_e step_q, step_d;

    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_FETCH_MAR: step_d = ST_FETCH_MDR;
            ST_FETCH_MDR: step_d = ST_FETCH_IR;
            ST_FETCH_IR:  step_d = ST_OPND_MAR;
            ST_OPND_MAR:  step_d = (opcode == OPC_HALT) ? ST_HALT : ST_OPND_MDR;
            ST_OPND_MDR:  step_d = ST_EXEC;
            ST_EXEC:      step_d = ST_FETCH_MAR;
            ST_HALT:      step_d = ST_HALT;
            default:      step_d = ST_FETCH_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_FETCH_MAR;
        end else begin
            step_q <= step_d;
        end
    end

    always_comb begin
        ctl = '0;
        unique case (step_q)
            ST_FETCH_MAR: ctl.mar_from_pc = 1'b1;
            ST_FETCH_MDR: ctl.mdr_load    = 1'b1;
            ST_FETCH_IR:  ctl.ir_load     = 1'b1;
            ST_OPND_MAR:  ctl.mar_from_ir = (opcode != OPC_HALT);
            ST_OPND_MDR:  ctl.mdr_load    = 1'b1;
            ST_EXEC: begin
                ctl.pc_inc   = 1'b1;
                ctl.acc_load = (opcode == OPC_LOAD);
                ctl.acc_add  = (opcode == OPC_ADD);
                ctl.mem_we   = (opcode == OPC_STORE);
            end
            default: ctl = '0;
        endcase
    end

    assign exec_o   = (step_q == ST_EXEC);
    assign halted_o = (step_q == ST_HALT);

    // R7
    exec_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_EXEC) |=> (step_q == ST_FETCH_MAR))
        else $error("sequencer did not return to fetch");

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_HALT) |=> (step_q == ST_HALT))
        else $error("halt state left without reset");

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctl,
    input  logic    exec_step,
    input  word_t   mem_rdata,
    output addr_t   mem_addr,
    output word_t   mem_wdata,
    output opcode_t opcode,
    output addr_t   pc_o,
    output word_t   acc_o
);

    addr_t  pc_q;
    addr_t  mar_q;
    word_t  mdr_q;
    instr_t ir_q;
    word_t  acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            acc_q <= '0;
        end else begin
            if (ctl.mar_from_pc) begin
                mar_q <= pc_q;
            end else if (ctl.mar_from_ir) begin
                mar_q <= ir_q.addr;
            end
            if (ctl.mdr_load) begin
                mdr_q <= mem_rdata;
            end
            if (ctl.ir_load) begin
                ir_q <= instr_t'(mdr_q);
            end
            if (ctl.acc_load) begin
                acc_q <= mdr_q;
            end else if (ctl.acc_add) begin
                acc_q <= alu_sum(acc_q, mdr_q);
            end
            if (ctl.pc_inc) begin
                pc_q <= addr_next(pc_q);
            end
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = acc_q;
    assign opcode    = ir_q.op;
    assign pc_o      = pc_q;
    assign acc_o     = acc_q;

    // R7
    pc_single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_q) |-> (pc_q == $past(pc_q) + ADDR_W'(1)))
        else $error("program counter jumped");

    // R4
    acc_only_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_q) |-> $past(exec_step))
        else $error("accumulator changed outside execute step");

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              halted_o
);

    ctrl_t   ctl;
    logic    exec_step;
    opcode_t opcode;
    addr_t   mem_addr;
    word_t   mem_wdata;
    word_t   mem_rdata;

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (opcode),
        .ctl      (ctl),
        .exec_o   (exec_step),
        .halted_o (halted_o)
    );

    acc_cpu_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .exec_step (exec_step),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .pc_o      (pc_o),
        .acc_o     (acc_o)
    );

    acc_cpu_mem u_mem (
        .clk        (clk),
        .rst        (rst),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .core_addr  (mem_addr),
        .core_we    (ctl.mem_we),
        .core_wdata (mem_wdata),
        .core_rdata (mem_rdata)
    );

    // R10
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> ($stable(pc_o) && $stable(acc_o) && halted_o))
        else $error("state moved while halted");

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && acc_o == '0 && !halted_o))
        else $error("reset did not clear visible state");

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_we = 1'b0;
    logic [3:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [3:0] pc_o;
    logic [7:0] acc_o;
    logic       halted_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [3:0] pc;
        logic [7:0] acc;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    logic halt_seen = 1'b0;

    always #2 clk = ~clk;

    acc_cpu u_acc_cpu (
        .clk      (clk),
        .rst      (rst),
        .ld_we    (ld_we),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .pc_o     (pc_o),
        .acc_o    (acc_o),
        .halted_o (halted_o)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_up();
        end
    end

    // monitor: pops one expected item each time the program counter moves
    int         step_cnt = 0;
    logic [3:0] prev_pc = '0;
    logic       prev_halt = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            step_cnt  = 0;
            prev_pc   = pc_o;
            prev_halt = 1'b0;
        end else begin
            step_cnt++;
            if (pc_o !== prev_pc) begin
                exp_t it;
                // R7: six cycles per instruction
                check(step_cnt == 6, "R7", "cycles per instruction", step_cnt, 6);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected pc advance", pc_o, prev_pc);
                end else begin
                    it = exp_q.pop_front();
                    check(pc_o == it.pc, it.tag, "pc", pc_o, it.pc);
                    check(acc_o == it.acc, it.tag, "acc", acc_o, it.acc);
                end
                step_cnt = 0;
                prev_pc  = pc_o;
            end
            if (halted_o && !prev_halt) begin
                // R10: halted four cycles after fetch starts
                check(step_cnt == 4, "R10", "halt latency", step_cnt, 4);
                check(exp_q.size() == 0, "R10", "items left at halt", exp_q.size(), 0);
                halt_seen = 1'b1;
            end
            prev_halt = halted_o;
        end
    end

    // driver: reference interpreter pushes expected items, then runs the core
    task automatic run_prog(input logic [7:0] img [16], input int max_steps,
                            input bit expect_halt, input bit poke);
        logic [7:0] m [16];
        bit         stored [16];
        logic [3:0] pc = '0;
        logic [7:0] acc = '0;
        int         wait_cnt;
        @(negedge clk);
        rst <= 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ld_we   <= 1'b1;
            ld_addr <= 4'(i);
            ld_data <= img[i];
            m[i]      = img[i];
            stored[i] = 1'b0;
        end
        @(negedge clk);
        ld_we <= 1'b0;
        @(negedge clk);
        // R1
        check(pc_o == 4'h0, "R1", "pc in reset", pc_o, 0);
        check(acc_o == 8'h00, "R1", "acc in reset", acc_o, 0);
        check(halted_o == 1'b0, "R1", "halted in reset", halted_o, 0);
        exp_q.delete();
        halt_seen = 1'b0;
        // R3: opcode in bits 7:4, address in bits 3:0
        for (int s = 0; s < max_steps; s++) begin
            logic [3:0] op;
            logic [3:0] a;
            string      tag;
            op = m[pc][7:4];
            a  = m[pc][3:0];
            if (op == 4'hF) break;
            case (op)
                4'h1: begin acc = m[a]; tag = stored[a] ? "R6" : "R3 R4"; end
                4'h2: begin acc = acc + m[a]; tag = "R5"; end
                4'h3: begin m[a] = acc; stored[a] = 1'b1; tag = "R6"; end
                default: tag = "R8";
            endcase
            if (pc == 4'hF) tag = "R9";
            pc = pc + 4'h1;
            exp_q.push_back('{pc: pc, acc: acc, tag: tag});
        end
        rst <= 1'b0;
        if (poke) begin
            // R2: preload attempt while running must be ignored
            repeat (10) @(negedge clk);
            ld_we   <= 1'b1;
            ld_addr <= 4'h9;
            ld_data <= 8'h55;
            @(negedge clk);
            ld_we <= 1'b0;
        end
        wait_cnt = 0;
        while ((exp_q.size() != 0 || (expect_halt && !halt_seen)) && wait_cnt < 2000) begin
            @(negedge clk);
            wait_cnt++;
        end
        check(wait_cnt < 2000, "R7", "run completion", wait_cnt, 2000);
        if (expect_halt) begin
            repeat (8) @(negedge clk);
            check(halted_o == 1'b1, "R10", "halted held", halted_o, 1);
            check(pc_o == pc, "R10", "pc frozen", pc_o, pc);
            check(acc_o == acc, "R10", "acc frozen", acc_o, acc);
        end
    endtask

    initial begin
        logic [7:0] img [16];

        // load, add, store, unrelated load, reload of stored cell
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h18; img[1] = 8'h29; img[2] = 8'h3A; img[3] = 8'h1B;
        img[4] = 8'h1A; img[5] = 8'hF0;
        img[8] = 8'h02; img[9] = 8'h03; img[11] = 8'h77;
        run_prog(img, 20, 1'b1, 1'b0);

        // modulo add, unused opcodes, ignored preload during run (R2)
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'h1C; img[1] = 8'h2D; img[2] = 8'h0F; img[3] = 8'h5E;
        img[4] = 8'h19; img[5] = 8'h29; img[6] = 8'hFF;
        img[9] = 8'h33; img[12] = 8'hC8; img[13] = 8'h64;
        run_prog(img, 20, 1'b1, 1'b1);
        check(acc_o == 8'h66, "R2", "acc after poked cell reload", acc_o, 8'h66);

        // program counter wrap through a memory of unused opcodes
        for (int i = 0; i < 16; i++) img[i] = 8'h40;
        img[5] = 8'h1F; img[15] = 8'h7A;
        run_prog(img, 18, 1'b0, 1'b0);

        // halt as the very first instruction
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
        img[0] = 8'hF3;
        run_prog(img, 4, 1'b1, 1'b0);

        finish_up();
    end

endmodule